// File: doc/BRIEF.md
# Match-Compare Operating-System Timer with Watchdog

The block keeps a 32-bit up-counter that advances by one on every clock in which the tick-enable input is high. Four 32-bit compare registers watch the counter. When the counter takes a value equal to a compare register and that channel's interrupt-enable bit is set, the block records the event in a sticky status register and raises the channel's own interrupt line. Software clears events by writing ones to the status register.

Channel 3 also serves as a one-shot watchdog. If the watchdog-enable bit is set when channel 3 matches, the block pulses a reset-request output for one cycle and disarms the watchdog by zeroing its register. Everything is reached through a simple register bus with a combinational read port. Software can load the counter at any time, and counting resumes from the loaded value.

Top module: `match_timer`

## Requirements
- R1: Register offsets: compare 0..3 at 0x00, 0x04, 0x08, 0x0C; counter at 0x10; status at 0x14 (bit n = channel n); watchdog enable at 0x18 (bit 0 arms); interrupt enable at 0x1C (bit n = channel n). Compare and watchdog registers read back what was written.
- R2: A write to 0x10 loads the counter with the written value and takes priority over a tick in the same cycle. Each tick afterwards adds one.
- R3: When the counter takes a value equal to compare register n and interrupt-enable bit n is 1, status bit n is set at that clock edge. With the enable bit at 0, status bit n is left unchanged.
- R4: Interrupt output bit n equals status bit n, so it stays high until software clears the bit.
- R5: A write to 0x14 clears exactly the status bits that are written as 1 and currently set, and the matching interrupt lines fall. Bits written as 0 are unaffected.
- R6: The interrupt-enable register stores only bits 11:0. Bits 31:12 read as zero.
- R7: A channel-3 match while watchdog bit 0 is 1 raises reset_req for exactly one cycle and clears the watchdog register to zero. This happens whatever the state of interrupt-enable bit 3. With bit 0 at 0, no request is made.
- R8: Reads of any offset not listed in R1 return zero.
- R9: Compares are evaluated on every cycle in which the counter takes a new value, whether by a tick or by a load. The counter wraps from 0xFFFFFFFF to 0 and raises no flag for the wrap.
- R10: Reset sets all registers to zero and drives irq and reset_req low.
- R11: When a status clear and a new enabled match on the same bit occur in the same cycle, the bit ends up set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick_en | input | 1 | Advance the counter by one this cycle |
| bus_addr | input | 8 | Register byte offset |
| bus_we | input | 1 | Write strobe |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Combinational read data for bus_addr |
| irq | output | 4 | Per-channel interrupt lines |
| reset_req | output | 1 | One-cycle system reset request |

## Verification
The assertions assume that the bus is idle and tick_en is low while reset is held. They also assume that the address holds steady whenever bus_we is high, so that a load of the counter can be traced to the bus value of the previous cycle. The bench drives every input at the falling clock edge and holds each write for exactly one cycle. It asserts reset before any bus traffic, so these assumptions always hold. The single cycle in which a status clear and a tick coincide is built on purpose to test the same-bit priority rule.

// File: rtl/match_timer_pkg.sv
package match_timer_pkg;
    localparam int DATA_W = 32;
    localparam int N_CH   = 4;
    localparam int IEN_W  = 12;
    localparam int ADDR_W = 8;

    typedef enum logic [ADDR_W-1:0] {
        OFS_CMP0   = 8'h00,
        OFS_CMP1   = 8'h04,
        OFS_CMP2   = 8'h08,
        OFS_CMP3   = 8'h0C,
        OFS_COUNT  = 8'h10,
        OFS_STATUS = 8'h14,
        OFS_WDOG   = 8'h18,
        OFS_IEN    = 8'h1C
    } reg_ofs_e;

    typedef struct packed {
        logic              we;
        logic [ADDR_W-1:0] addr;
        logic [DATA_W-1:0] wdata;
    } bus_req_t;

    // Compare-register word offset of channel n
    function automatic logic [ADDR_W-1:0] cmp_ofs(input int n);
        return ADDR_W'(n * 4);
    endfunction

    function automatic logic wr_hit(input bus_req_t req, input logic [ADDR_W-1:0] ofs);
        return req.we && (req.addr == ofs);
    endfunction
endpackage

// File: rtl/mt_counter.sv
module mt_counter
    import match_timer_pkg::*;
#(
    parameter int W = DATA_W
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         tick_en,
    input  logic         load,
    input  logic [W-1:0] load_val,
    output logic [W-1:0] cnt_q,
    output logic [W-1:0] cnt_nxt,
    output logic         cnt_upd
);
    // A load beats a tick; increment wraps naturally
    always_comb begin
        cnt_upd = load || tick_en;
        cnt_nxt = load ? load_val : (cnt_q + W'(1));
    end

    always_ff @(posedge clk) begin
        if (rst)
            cnt_q <= '0;
        else if (cnt_upd)
            cnt_q <= cnt_nxt;
    end
endmodule

// File: rtl/mt_channel.sv
module mt_channel
    import match_timer_pkg::*;
#(
    parameter int W = DATA_W
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         wr_en,
    input  logic [W-1:0] wr_val,
    input  logic         cnt_upd,
    input  logic [W-1:0] cnt_nxt,
    output logic [W-1:0] cmp_q,
    output logic         hit
);
    always_ff @(posedge clk) begin
        if (rst)
            cmp_q <= '0;
        else if (wr_en)
            cmp_q <= wr_val;
    end

    assign hit = cnt_upd && (cnt_nxt == cmp_q);
endmodule

// File: rtl/mt_event.sv
module mt_event
    import match_timer_pkg::*;
#(
    parameter int NC = N_CH,
    parameter int W  = DATA_W,
    parameter int IW = IEN_W
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [NC-1:0] hit,
    input  logic          sts_wr,
    input  logic [NC-1:0] sts_clr_mask,
    input  logic          ien_wr,
    input  logic [IW-1:0] ien_val,
    input  logic          wdog_wr,
    input  logic [W-1:0]  wdog_val,
    output logic [NC-1:0] sts_q,
    output logic [IW-1:0] ien_q,
    output logic [W-1:0]  wdog_q,
    output logic          reset_req_q
);
    localparam int WD_CH = NC - 1;

    logic [NC-1:0] set_v, clr_v;
    logic          wd_fire;

    always_comb begin
        set_v   = hit & ien_q[NC-1:0];
        clr_v   = sts_wr ? (sts_clr_mask & sts_q) : '0;
        wd_fire = hit[WD_CH] && wdog_q[0];
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            sts_q       <= '0;
            ien_q       <= '0;
            wdog_q      <= '0;
            reset_req_q <= 1'b0;
        end else begin
            // set dominates a simultaneous clear of the same bit
            sts_q       <= (sts_q & ~clr_v) | set_v;
            reset_req_q <= wd_fire;
            if (ien_wr)
                ien_q <= ien_val;
            if (wd_fire)
                wdog_q <= '0;
            else if (wdog_wr)
                wdog_q <= wdog_val;
        end
    end
endmodule

// File: rtl/match_timer.sv
module match_timer
    import match_timer_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              tick_en,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_we,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    output logic [N_CH-1:0]   irq,
    output logic              reset_req
);
    bus_req_t req;
    assign req = '{we: bus_we, addr: bus_addr, wdata: bus_wdata};

    logic [DATA_W-1:0] cnt_q, cnt_nxt;
    logic              cnt_upd;
    logic [N_CH-1:0]   hit;
    logic [DATA_W-1:0] cmp_q [N_CH];
    logic [N_CH-1:0]   sts_q;
    logic [IEN_W-1:0]  ien_q;
    logic [DATA_W-1:0] wdog_q;

    mt_counter #(.W(DATA_W)) u_cnt (
        .clk      (clk),
        .rst      (rst),
        .tick_en  (tick_en),
        .load     (wr_hit(req, OFS_COUNT)),
        .load_val (req.wdata),
        .cnt_q    (cnt_q),
        .cnt_nxt  (cnt_nxt),
        .cnt_upd  (cnt_upd)
    );

    for (genvar n = 0; n < N_CH; n++) begin : g_ch
        mt_channel #(.W(DATA_W)) u_ch (
            .clk     (clk),
            .rst     (rst),
            .wr_en   (wr_hit(req, cmp_ofs(n))),
            .wr_val  (req.wdata),
            .cnt_upd (cnt_upd),
            .cnt_nxt (cnt_nxt),
            .cmp_q   (cmp_q[n]),
            .hit     (hit[n])
        );
    end

    mt_event #(.NC(N_CH), .W(DATA_W), .IW(IEN_W)) u_evt (
        .clk          (clk),
        .rst          (rst),
        .hit          (hit),
        .sts_wr       (wr_hit(req, OFS_STATUS)),
        .sts_clr_mask (req.wdata[N_CH-1:0]),
        .ien_wr       (wr_hit(req, OFS_IEN)),
        .ien_val      (req.wdata[IEN_W-1:0]),
        .wdog_wr      (wr_hit(req, OFS_WDOG)),
        .wdog_val     (req.wdata),
        .sts_q        (sts_q),
        .ien_q        (ien_q),
        .wdog_q       (wdog_q),
        .reset_req_q  (reset_req)
    );

    assign irq = sts_q;

    always_comb begin
        bus_rdata = '0;
        for (int n = 0; n < N_CH; n++)
            if (req.addr == cmp_ofs(n))
                bus_rdata = cmp_q[n];
        case (req.addr)
            OFS_COUNT:  bus_rdata = cnt_q;
            OFS_STATUS: bus_rdata = DATA_W'(sts_q);
            OFS_WDOG:   bus_rdata = wdog_q;
            OFS_IEN:    bus_rdata = DATA_W'(ien_q);
            default:    ;
        endcase
    end
endmodule

// File: rtl/match_timer_chk.sv
module match_timer_chk
    import match_timer_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic [ADDR_W-1:0] bus_addr,
    input logic              bus_we,
    input logic [DATA_W-1:0] bus_wdata,
    input logic [DATA_W-1:0] bus_rdata,
    input logic [N_CH-1:0]   irq,
    input logic              reset_req,
    input logic [DATA_W-1:0] cnt_q,
    input logic [IEN_W-1:0]  ien_q,
    input logic [DATA_W-1:0] wdog_q
);
    // R2: a counter write shows up as the counter value next cycle
    assert_count_load_R2: assert property (@(posedge clk) disable iff (rst)
        (bus_we && bus_addr == OFS_COUNT) |=> (cnt_q == $past(bus_wdata)));

    // R3: an interrupt line only rises for a channel that was enabled
    assert_rise_needs_enable_R3: assert property (@(posedge clk) disable iff (rst)
        ((irq & ~$past(irq) & ~$past(ien_q[N_CH-1:0])) == '0));

    // R5: an interrupt line only falls after a status write
    assert_fall_needs_clear_R5: assert property (@(posedge clk) disable iff (rst)
        ((~irq & $past(irq)) != '0) |-> $past(bus_we && bus_addr == OFS_STATUS));

    // R6: upper enable bits never read back
    assert_ien_upper_zero_R6: assert property (@(posedge clk) disable iff (rst)
        (bus_addr == OFS_IEN) |-> (bus_rdata[DATA_W-1:IEN_W] == '0));

    // R7: a request leaves the watchdog disarmed and lasts one cycle
    assert_wdog_disarm_R7: assert property (@(posedge clk) disable iff (rst)
        reset_req |-> (wdog_q == '0));
    assert_req_one_cycle_R7: assert property (@(posedge clk) disable iff (rst)
        reset_req |=> !reset_req);

    // R10: outputs are low after a reset edge
    assert_reset_quiet_R10: assert property (@(posedge clk)
        $past(rst) |-> (irq == '0 && !reset_req));
endmodule

bind match_timer match_timer_chk u_chk (.*);

// File: tb/match_timer_test.sv
module match_timer_test;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        tick_en = 1'b0;
    logic [7:0]  bus_addr = '0;
    logic        bus_we = 1'b0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [3:0]  irq;
    logic        reset_req;

    int checks = 0;
    int errors = 0;
    int req_pulses = 0;
    bit done = 0;

    match_timer uut (
        .clk(clk), .rst(rst), .tick_en(tick_en), .bus_addr(bus_addr),
        .bus_we(bus_we), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .irq(irq), .reset_req(reset_req)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    always @(negedge clk) if (!rst && reset_req) req_pulses++;

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual 0x%08h expected 0x%08h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_we = 1'b1;
        @(negedge clk);
        bus_we = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_addr = a;
        #1 d = bus_rdata;
    endtask

    task automatic ticks(input int n);
        @(negedge clk);
        tick_en = 1'b1;
        repeat (n) @(negedge clk);
        tick_en = 1'b0;
    endtask

    task automatic t_reset;
        logic [31:0] d;
        for (int a = 0; a < 8; a++) begin
            rd(8'(a * 4), d);
            check("R10 register reset", d, 32'h0);
        end
        check("R10 irq reset", {28'h0, irq}, 32'h0);
        check("R10 reset_req reset", {31'h0, reset_req}, 32'h0);
    endtask

    task automatic t_map;
        logic [31:0] d;
        for (int n = 0; n < 4; n++) wr(8'(n * 4), 32'hA000_0000 + 32'(n));
        for (int n = 0; n < 4; n++) begin
            rd(8'(n * 4), d);
            check("R1 compare readback", d, 32'hA000_0000 + 32'(n));
        end
        wr(8'h18, 32'h0000_0002);
        rd(8'h18, d); check("R1 watchdog readback", d, 32'h2);
        wr(8'h18, 32'h0);
        wr(8'h1C, 32'hFFFF_FFFF);
        rd(8'h1C, d); check("R6 enable width", d, 32'h0000_0FFF);
        wr(8'h1C, 32'h0);
        rd(8'h20, d); check("R8 unmapped 0x20", d, 32'h0);
        rd(8'h04 + 8'h80, d); check("R8 unmapped 0x84", d, 32'h0);
    endtask

    task automatic t_load;
        logic [31:0] d;
        wr(8'h10, 32'd100);
        rd(8'h10, d); check("R2 load", d, 32'd100);
        ticks(5);
        rd(8'h10, d); check("R2 count on", d, 32'd105);
        // load beats a tick in the same cycle
        @(negedge clk);
        tick_en = 1'b1; bus_addr = 8'h10; bus_wdata = 32'd7; bus_we = 1'b1;
        @(negedge clk);
        tick_en = 1'b0; bus_we = 1'b0;
        rd(8'h10, d); check("R2 load priority", d, 32'd7);
    endtask

    task automatic t_match;
        logic [31:0] d;
        wr(8'h10, 32'd105);
        wr(8'h00, 32'd110);
        wr(8'h04, 32'd110);
        wr(8'h08, 32'd9000);
        wr(8'h0C, 32'd9000);
        wr(8'h1C, 32'h1);
        ticks(4);
        check("R3 no early match", {28'h0, irq}, 32'h0);
        ticks(1);
        rd(8'h14, d); check("R3 enabled channel sets, disabled does not", d, 32'h1);
        ticks(3);
        check("R4 irq held", {28'h0, irq}, 32'h1);
        wr(8'h14, 32'h6);
        check("R5 unset bits ignored", {28'h0, irq}, 32'h1);
        wr(8'h14, 32'h1);
        check("R5 clear", {28'h0, irq}, 32'h0);
        rd(8'h14, d); check("R5 status cleared", d, 32'h0);
    endtask

    task automatic t_load_match_and_priority;
        logic [31:0] d;
        wr(8'h00, 32'd201);
        wr(8'h1C, 32'h1);
        wr(8'h10, 32'd201);
        rd(8'h14, d); check("R9 match on load", d, 32'h1);
        wr(8'h10, 32'd200);
        @(negedge clk);
        tick_en = 1'b1; bus_addr = 8'h14; bus_wdata = 32'h1; bus_we = 1'b1;
        @(negedge clk);
        tick_en = 1'b0; bus_we = 1'b0;
        rd(8'h14, d); check("R11 set wins over clear", d, 32'h1);
        wr(8'h14, 32'h1);
    endtask

    task automatic t_wdog;
        logic [31:0] d;
        int p0;
        wr(8'h1C, 32'h0);
        wr(8'h0C, 32'd300);
        wr(8'h18, 32'h2);
        wr(8'h10, 32'd298);
        p0 = req_pulses;
        ticks(3);
        check("R7 bit0 clear: no request", 32'(req_pulses - p0), 32'd0);
        wr(8'h18, 32'h1);
        wr(8'h10, 32'd299);
        p0 = req_pulses;
        @(negedge clk); tick_en = 1'b1;
        @(posedge clk); #1;
        check("R7 request raised", {31'h0, reset_req}, 32'h1);
        @(negedge clk); tick_en = 1'b0;
        @(posedge clk); #1;
        check("R7 request one cycle", {31'h0, reset_req}, 32'h0);
        check("R7 pulse count", 32'(req_pulses - p0), 32'd1);
        rd(8'h18, d); check("R7 watchdog disarmed", d, 32'h0);
        rd(8'h14, d); check("R7 status untouched when disabled", d, 32'h0);
    endtask

    task automatic t_wrap;
        logic [31:0] d;
        for (int n = 0; n < 4; n++) wr(8'(n * 4), 32'h1234);
        wr(8'h1C, 32'hF);
        wr(8'h10, 32'hFFFF_FFFE);
        ticks(3);
        rd(8'h10, d); check("R9 wrap value", d, 32'h1);
        rd(8'h14, d); check("R9 wrap raises nothing", d, 32'h0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        t_reset();
        t_map();
        t_load();
        t_match();
        t_load_match_and_priority();
        t_wdog();
        t_wrap();
        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog: actual hung expected done");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule